// File: doc/BRIEF.md
# Receive Descriptor Writeback Engine

This block is the receive side of a descriptor-ring DMA for a network controller. Frames arrive one byte per beat on a valid/ready stream. For each frame the engine reads the descriptor at the current ring position: a control word, a size word and a buffer address. If software owns nothing there, the frame is swallowed. Otherwise the bytes are packed into 32-bit little-endian words and written to the buffer. The engine then overwrites the control word with a completion status that carries the length and gives ownership back to software. Last, it steps or wraps the ring position.

Every frame is also sorted by its destination address into unicast, multicast or broadcast. Running totals of stored frames, bytes and the two group classes are kept for software to sample. The first twelve bytes of each frame are staged on chip. Runt frames therefore never reach memory, and the staged bytes feed the destination classifier.

Top module: `rxwb_top`

## Requirements
- R1: While no frame is in progress and `rx_en` is low, `s_ready` stays low, so no frame is started.
- R2: A frame whose last byte arrives before byte 12 is fully consumed with no memory access. It causes one `evt_rx_done` pulse and leaves counters and `cur_desc` unchanged.
- R3: The engine reads the descriptor words at `cur_desc`, `cur_desc+4` and `cur_desc+8` (control, size, buffer address). If bit 31 of the control word is 0, the rest of the frame is consumed and one `evt_no_desc` pulse is raised. Nothing is written, and counters and `cur_desc` stay unchanged.
- R4: Frame byte k lands at buffer address + k, in byte lane k mod 4 of its 32-bit word. A final partial word is written with only the lanes it fills, so bytes past the frame end are left untouched.
- R5: On success the control word at `cur_desc` is overwritten with ((length + 4) << 16) | 0x0300. This value has bit 31 clear.
- R6: After the status write, `cur_desc` becomes `ring_base` if bit 15 of the size word was set, and `cur_desc + 32` otherwise. A `ring_load` pulse loads `ring_base` directly.
- R7: A frame is broadcast when its first six bytes are all 0xFF, unicast when bit 0 of byte 0 is 0, and multicast otherwise. `stat_bcast` and `stat_mcast` count successful frames of those classes.
- R8: Each successful frame adds length + 4 to `stat_bytes` and 1 to `stat_frames`. Dropped frames change neither.
- R9: `s_ready` is low in every cycle where a memory access is pending.
- R10: `evt_rx_done` is a single-cycle pulse per completed frame, and never coincides with `evt_no_desc`.
- R11: After reset, `s_ready` follows `rx_en`, `mem_req` is low, and all counters and `cur_desc` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable, sampled at frame start |
| ring_base | input | AW | Byte address of the first descriptor |
| ring_load | input | 1 | Loads `ring_base` into the ring position |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of a frame |
| s_ready | output | 1 | Engine accepts a byte |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte-lane enables for writes |
| mem_ack | input | 1 | Access done; read data valid |
| mem_rdata | input | 32 | Read data |
| evt_rx_done | output | 1 | Pulse: frame completed or runt dropped |
| evt_no_desc | output | 1 | Pulse: no owned descriptor, frame dropped |
| cur_desc | output | AW | Current descriptor address |
| stat_bytes | output | STAT_W | Bytes received including 4 per frame for CRC |
| stat_frames | output | STAT_W | Frames stored |
| stat_mcast | output | STAT_W | Multicast frames stored |
| stat_bcast | output | STAT_W | Broadcast frames stored |

## Verification
The bench builds the engine with AW = 12, LEN_W = 10 and STAT_W = 16. In this configuration a 1024-word memory model covers every address, so each descriptor and buffer byte can be inspected. It sweeps every frame length from 1 to 40 bytes. That range covers all runt lengths, the exact twelve-byte boundary where the staged words are the whole frame, and every final-word fill of 1 to 4 lanes. The three destination classes rotate across the sweep, and some descriptors are left unowned. A four-slot ring reaches the wrap flag about every fourth stored frame.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;

   typedef enum logic [3:0] {
      S_COLLECT,
      S_RD_CTL,
      S_RD_SIZE,
      S_RD_BUF,
      S_FLUSH,
      S_STREAM,
      S_WDATA,
      S_WBACK,
      S_DRAIN
   } rxwb_state_e;

   typedef enum logic [1:0] {
      C_UNI   = 2'd0,
      C_MULTI = 2'd1,
      C_BCAST = 2'd2
   } dest_class_e;

   localparam int OWN_BIT       = 31;
   localparam int WRAP_BIT      = 15;
   localparam int DEST_BYTES    = 6;
   localparam int CRC_BYTES     = 4;
   localparam logic [15:0] DONE_FLAGS = 16'h0300;

endpackage

// File: rtl/rxwb_classify.sv
module rxwb_classify
   import rxwb_pkg::*;
(
   input  logic [8*DEST_BYTES-1:0] dest,
   output dest_class_e             cls
);

   logic [DEST_BYTES-1:0] is_ff;

   for (genvar i = 0; i < DEST_BYTES; i++) begin : g_ff
      assign is_ff[i] = (dest[8*i +: 8] == 8'hFF);
   end

   always_comb begin
      if (&is_ff)
         cls = C_BCAST;
      else if (!dest[0])
         cls = C_UNI;
      else
         cls = C_MULTI;
   end

endmodule

// File: rtl/rxwb_ring_ptr.sv
module rxwb_ring_ptr #(
   parameter int AW         = 32,
   parameter int DESC_BYTES = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          advance,
   input  logic          wrap,
   output logic [AW-1:0] cur
);

   localparam logic [AW-1:0] STRIDE = AW'(DESC_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cur <= '0;
      else if (load)
         cur <= base;
      else if (advance)
         cur <= wrap ? base : cur + STRIDE;
   end

endmodule

// File: rtl/rxwb_stats.sv
module rxwb_stats
   import rxwb_pkg::*;
#(
   parameter int STAT_W = 32,
   parameter int LEN_W  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [LEN_W-1:0]  len,
   input  dest_class_e       cls,
   output logic [STAT_W-1:0] bytes_q,
   output logic [STAT_W-1:0] frames_q,
   output logic [STAT_W-1:0] mcast_q,
   output logic [STAT_W-1:0] bcast_q
);

   localparam int NCNT = 3;

   logic [NCNT-1:0] inc;
   assign inc = {commit && (cls == C_BCAST), commit && (cls == C_MULTI), commit};

   for (genvar i = 0; i < NCNT; i++) begin : g_cnt
      logic [STAT_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (inc[i])
            q <= q + 1'b1;
      end
   end

   assign frames_q = g_cnt[0].q;
   assign mcast_q  = g_cnt[1].q;
   assign bcast_q  = g_cnt[2].q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         bytes_q <= '0;
      else if (commit)
         bytes_q <= bytes_q + STAT_W'(len) + STAT_W'(CRC_BYTES);
   end

endmodule

// File: rtl/rxwb_top.sv
module rxwb_top
   import rxwb_pkg::*;
#(
   parameter int AW         = 32,
   parameter int LEN_W      = 14,
   parameter int STAT_W     = 32,
   parameter int MIN_FRAME  = 12,
   parameter int DESC_BYTES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic [AW-1:0]     ring_base,
   input  logic              ring_load,
   input  logic              s_valid,
   input  logic [7:0]        s_data,
   input  logic              s_last,
   output logic              s_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [31:0]       mem_wdata,
   output logic [3:0]        mem_be,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              evt_rx_done,
   output logic              evt_no_desc,
   output logic [AW-1:0]     cur_desc,
   output logic [STAT_W-1:0] stat_bytes,
   output logic [STAT_W-1:0] stat_frames,
   output logic [STAT_W-1:0] stat_mcast,
   output logic [STAT_W-1:0] stat_bcast
);

   localparam int STAGE_WORDS = MIN_FRAME / 4;
   localparam int FIDX_W      = $clog2(STAGE_WORDS);
   localparam int SIDX_W      = $clog2(MIN_FRAME);
   localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_FRAME);
   localparam logic [FIDX_W-1:0] FIDX_LAST = FIDX_W'(STAGE_WORDS - 1);

   // elaboration-time parameter checks
   if (MIN_FRAME % 4 != 0 || MIN_FRAME < 8) begin : g_bad_min
      $error("MIN_FRAME must be a multiple of 4 and at least 8");
   end
   if (LEN_W > 15 || LEN_W <= SIDX_W) begin : g_bad_len
      $error("LEN_W must exceed the staging index width and stay below 16");
   end
   if (DESC_BYTES < 16 || (DESC_BYTES & (DESC_BYTES - 1)) != 0) begin : g_bad_desc
      $error("DESC_BYTES must be a power of two of at least 16");
   end
   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("AW must lie between 8 and 32");
   end

   rxwb_state_e        state;
   logic [LEN_W-1:0]   cnt;
   logic               last_seen;
   logic [7:0]         stage [MIN_FRAME];
   logic [31:0]        stage_word [STAGE_WORDS];
   logic [AW-1:0]      buf_addr;
   logic [AW-1:0]      wr_addr;
   logic               wrap_flag;
   logic [FIDX_W-1:0]  flush_idx;
   logic [31:0]        acc;
   logic [3:0]         acc_be;
   logic [1:0]         lane;
   logic [LEN_W-1:0]   cnt_nx;
   logic               accept;
   logic               acked;
   logic               busy;
   logic               in_wback;
   logic [8*DEST_BYTES-1:0] dest;
   dest_class_e        cls;
   logic [15:0]        len_field;

   for (genvar w = 0; w < STAGE_WORDS; w++) begin : g_sword
      assign stage_word[w] = {stage[4*w+3], stage[4*w+2], stage[4*w+1], stage[4*w]};
   end

   for (genvar d = 0; d < DEST_BYTES; d++) begin : g_dest
      assign dest[8*d +: 8] = stage[d];
   end

   assign lane      = cnt[1:0];
   assign cnt_nx    = cnt + 1'b1;
   assign len_field = 16'(cnt) + 16'(CRC_BYTES);
   assign busy      = (state != S_COLLECT) || (cnt != '0);
   assign in_wback  = (state == S_WBACK);

   // stream handshake: never depends on s_valid
   always_comb begin
      unique case (state)
         S_COLLECT:         s_ready = (cnt == '0) ? rx_en : 1'b1;
         S_STREAM, S_DRAIN: s_ready = 1'b1;
         default:           s_ready = 1'b0;
      endcase
   end

   assign accept = s_valid && s_ready;

   // memory port decode
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cur_desc;
      mem_wdata = '0;
      mem_be    = 4'hF;
      unique case (state)
         S_RD_CTL: begin
            mem_req  = 1'b1;
         end
         S_RD_SIZE: begin
            mem_req  = 1'b1;
            mem_addr = cur_desc + AW'(4);
         end
         S_RD_BUF: begin
            mem_req  = 1'b1;
            mem_addr = cur_desc + AW'(8);
         end
         S_FLUSH: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = buf_addr + AW'({flush_idx, 2'b00});
            mem_wdata = stage_word[flush_idx];
         end
         S_WDATA: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = wr_addr;
            mem_wdata = acc;
            mem_be    = acc_be;
         end
         S_WBACK: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = {len_field, DONE_FLAGS};
         end
         default: ;
      endcase
   end

   assign acked = mem_req && mem_ack;

   // control sequence
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= S_COLLECT;
         cnt         <= '0;
         last_seen   <= 1'b0;
         buf_addr    <= '0;
         wr_addr     <= '0;
         wrap_flag   <= 1'b0;
         flush_idx   <= '0;
         acc         <= '0;
         acc_be      <= '0;
         evt_rx_done <= 1'b0;
         evt_no_desc <= 1'b0;
      end else begin
         evt_rx_done <= 1'b0;
         evt_no_desc <= 1'b0;
         unique case (state)
            S_COLLECT: begin
               if (accept) begin
                  if (s_last && (cnt_nx < MIN_LEN)) begin
                     cnt         <= '0;
                     evt_rx_done <= 1'b1;
                  end else begin
                     cnt <= cnt_nx;
                     if (cnt_nx == MIN_LEN) begin
                        last_seen <= s_last;
                        state     <= S_RD_CTL;
                     end
                  end
               end
            end
            S_RD_CTL: begin
               if (acked) begin
                  if (!mem_rdata[OWN_BIT]) begin
                     evt_no_desc <= 1'b1;
                     if (last_seen) begin
                        cnt       <= '0;
                        last_seen <= 1'b0;
                        state     <= S_COLLECT;
                     end else begin
                        state <= S_DRAIN;
                     end
                  end else begin
                     state <= S_RD_SIZE;
                  end
               end
            end
            S_RD_SIZE: begin
               if (acked) begin
                  wrap_flag <= mem_rdata[WRAP_BIT];
                  state     <= S_RD_BUF;
               end
            end
            S_RD_BUF: begin
               if (acked) begin
                  buf_addr  <= {mem_rdata[AW-1:2], 2'b00};
                  flush_idx <= '0;
                  state     <= S_FLUSH;
               end
            end
            S_FLUSH: begin
               if (acked) begin
                  if (flush_idx == FIDX_LAST)
                     state <= last_seen ? S_WBACK : S_STREAM;
                  else
                     flush_idx <= flush_idx + 1'b1;
               end
            end
            S_STREAM: begin
               if (accept) begin
                  acc[8*lane +: 8] <= s_data;
                  acc_be[lane]     <= 1'b1;
                  cnt              <= cnt_nx;
                  if (lane == 2'd3 || s_last) begin
                     wr_addr   <= buf_addr + AW'({cnt[LEN_W-1:2], 2'b00});
                     last_seen <= s_last;
                     state     <= S_WDATA;
                  end
               end
            end
            S_WDATA: begin
               if (acked) begin
                  acc    <= '0;
                  acc_be <= '0;
                  state  <= last_seen ? S_WBACK : S_STREAM;
               end
            end
            S_WBACK: begin
               if (acked) begin
                  evt_rx_done <= 1'b1;
                  cnt         <= '0;
                  last_seen   <= 1'b0;
                  state       <= S_COLLECT;
               end
            end
            S_DRAIN: begin
               if (accept && s_last) begin
                  cnt   <= '0;
                  state <= S_COLLECT;
               end
            end
            default: state <= S_COLLECT;
         endcase
      end
   end

   // staging capture for the first MIN_FRAME bytes
   always_ff @(posedge clk) begin
      if (state == S_COLLECT && accept)
         stage[cnt[SIDX_W-1:0]] <= s_data;
   end

   logic unused_rdata;
   assign unused_rdata = ^mem_rdata[1:0];

   rxwb_classify u_cls (
      .dest (dest),
      .cls  (cls)
   );

   rxwb_ring_ptr #(
      .AW         (AW),
      .DESC_BYTES (DESC_BYTES)
   ) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ring_load),
      .base    (ring_base),
      .advance (in_wback && acked),
      .wrap    (wrap_flag),
      .cur     (cur_desc)
   );

   rxwb_stats #(
      .STAT_W (STAT_W),
      .LEN_W  (LEN_W)
   ) u_stats (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (in_wback && acked),
      .len      (cnt),
      .cls      (cls),
      .bytes_q  (stat_bytes),
      .frames_q (stat_frames),
      .mcast_q  (stat_mcast),
      .bcast_q  (stat_bcast)
   );

endmodule

// File: rtl/rxwb_chk.sv
module rxwb_chk #(
   parameter int AW     = 32,
   parameter int STAT_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_en,
   input logic              s_ready,
   input logic              mem_req,
   input logic              mem_ack,
   input logic [31:0]       mem_wdata,
   input logic [3:0]        mem_be,
   input logic              evt_rx_done,
   input logic              evt_no_desc,
   input logic              ring_load,
   input logic [AW-1:0]     cur_desc,
   input logic [STAT_W-1:0] stat_frames,
   input logic              busy,
   input logic              in_wback
);

   // R1: no new frame is accepted while receive is disabled
   a_r1_refuse_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !rx_en) |-> !s_ready);

   // R9: stream held off during any memory access
   a_r9_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !s_ready);

   // R5: completion word carries the done flags and is written in full
   a_r5_status_word: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wback && mem_req) |-> (mem_wdata[15:0] == 16'h0300 && mem_be == 4'hF));

   // R6: ring position moves only on a status write or a load
   a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ring_load) && !$past(in_wback && mem_ack)) |-> $stable(cur_desc));

   // R10: the two events never coincide
   a_r10_evt_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_rx_done && evt_no_desc));

   // R8: frame count steps by one together with a completion pulse
   a_r8_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(stat_frames) |-> (evt_rx_done && stat_frames == $past(stat_frames) + 1'b1));

endmodule

bind rxwb_top rxwb_chk #(
   .AW     (AW),
   .STAT_W (STAT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_en       (rx_en),
   .s_ready     (s_ready),
   .mem_req     (mem_req),
   .mem_ack     (mem_ack),
   .mem_wdata   (mem_wdata),
   .mem_be      (mem_be),
   .evt_rx_done (evt_rx_done),
   .evt_no_desc (evt_no_desc),
   .ring_load   (ring_load),
   .cur_desc    (cur_desc),
   .stat_frames (stat_frames),
   .busy        (busy),
   .in_wback    (in_wback)
);

// File: tb/rxwb_top_tb_top.sv
`timescale 1ns/1ps
module rxwb_top_tb_top;

   localparam int AW     = 12;
   localparam int LEN_W  = 10;
   localparam int STAT_W = 16;
   localparam int RING   = 256;   // 0x100
   localparam int BUF0   = 512;   // 0x200
   localparam int SLOTS  = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rx_en = 1'b1;
   logic [AW-1:0]     ring_base = AW'(RING);
   logic              ring_load = 1'b0;
   logic              s_valid = 1'b0;
   logic [7:0]        s_data = 8'h00;
   logic              s_last = 1'b0;
   logic              s_ready;
   logic              mem_req, mem_we;
   logic [AW-1:0]     mem_addr;
   logic [31:0]       mem_wdata;
   logic [3:0]        mem_be;
   logic              mem_ack = 1'b0;
   logic [31:0]       mem_rdata = '0;
   logic              evt_rx_done, evt_no_desc;
   logic [AW-1:0]     cur_desc;
   logic [STAT_W-1:0] stat_bytes, stat_frames, stat_mcast, stat_bcast;

   always #2 clk = ~clk;

   rxwb_top #(.AW(AW), .LEN_W(LEN_W), .STAT_W(STAT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
      .ring_load(ring_load), .s_valid(s_valid), .s_data(s_data),
      .s_last(s_last), .s_ready(s_ready), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .evt_rx_done(evt_rx_done), .evt_no_desc(evt_no_desc),
      .cur_desc(cur_desc), .stat_bytes(stat_bytes),
      .stat_frames(stat_frames), .stat_mcast(stat_mcast),
      .stat_bcast(stat_bcast)
   );

   // memory model: one access every two cycles
   logic [31:0] mem [1024];
   int n_wr = 0, n_rd = 0, n_done = 0, n_nd = 0, n_hold_bad = 0, n_wide = 0;
   logic done_d = 1'b0;

   always @(posedge clk) begin
      if (mem_req && !mem_ack) begin
         mem_ack   <= 1'b1;
         mem_rdata <= mem[mem_addr[11:2]];
         if (mem_we) begin
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            n_wr <= n_wr + 1;
         end else begin
            n_rd <= n_rd + 1;
         end
      end else begin
         mem_ack <= 1'b0;
      end
      if (evt_rx_done) n_done <= n_done + 1;
      if (evt_no_desc) n_nd <= n_nd + 1;
      done_d <= evt_rx_done;
      if (evt_rx_done && done_d) n_wide <= n_wide + 1;
   end

   always @(negedge clk) if (rst_n && mem_req && s_ready) n_hold_bad++;

   int n_tests = 0, n_fail = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] fbyte(int k, int cls, int seed);
      if (cls == 2 && k < 6) return 8'hFF;
      if (k == 0) return (cls == 0) ? 8'h02 : 8'h01;
      return 8'((seed * 13 + k * 7 + 3) & 255);
   endfunction

   task automatic send_frame(int n, int cls, int seed);
      logic rdy;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         s_valid = 1'b1;
         s_data  = fbyte(k, cls, seed);
         s_last  = (k == n - 1);
         forever begin
            rdy = s_ready;
            @(posedge clk);
            if (rdy) break;
            @(negedge clk);
         end
      end
      @(negedge clk);
      s_valid = 1'b0;
      s_last  = 1'b0;
   endtask

   int exp_ptr = RING;
   int e_bytes = 0, e_frames = 0, e_mc = 0, e_bc = 0;

   task automatic run_frame(int n, int cls, int seed, bit owned);
      int slot, dw, bufa, wr0, rd0, d0, nd0, bad;
      slot = (exp_ptr - RING) / 32;
      dw   = exp_ptr / 4;
      bufa = BUF0 + 64 * slot;
      mem[dw]     = owned ? 32'h8000_0000 : 32'h0000_1234;
      mem[dw + 1] = 32'h0000_0040 | ((slot == SLOTS - 1) ? 32'h8000 : 32'h0);
      mem[dw + 2] = 32'(bufa);
      for (int i = 0; i < 16; i++) mem[bufa / 4 + i] = 32'hAAAA_AAAA;
      wr0 = n_wr; rd0 = n_rd; d0 = n_done; nd0 = n_nd;
      send_frame(n, cls, seed);
      repeat (40) @(negedge clk);
      if (n < 12) begin
         chk(n_wr == wr0 && n_rd == rd0, "R2 runt touches memory", n_wr + n_rd, wr0 + rd0);
         chk(n_done == d0 + 1, "R2 runt done pulse", n_done, d0 + 1);
         chk(cur_desc == AW'(exp_ptr), "R2 runt pointer", cur_desc, exp_ptr);
         chk(stat_frames == STAT_W'(e_frames), "R8 runt frames", stat_frames, e_frames);
      end else if (!owned) begin
         chk(n_nd == nd0 + 1 && n_done == d0, "R3 no-desc event", n_nd - nd0, 1);
         chk(n_wr == wr0, "R3 no writes", n_wr, wr0);
         chk(mem[dw] == 32'h0000_1234, "R3 descriptor untouched", mem[dw], 32'h1234);
         chk(cur_desc == AW'(exp_ptr), "R3 pointer held", cur_desc, exp_ptr);
         chk(stat_bytes == STAT_W'(e_bytes), "R8 bytes held on drop", stat_bytes, e_bytes);
      end else begin
         chk(mem[dw] == ((32'(n + 4) << 16) | 32'h300), "R5 status word", mem[dw],
             (32'(n + 4) << 16) | 32'h300);
         bad = 0;
         for (int k = 0; k < n; k++)
            if (mem[(bufa + k) / 4][8 * (k % 4) +: 8] != fbyte(k, cls, seed)) bad++;
         chk(bad == 0, "R4 buffer bytes", bad, 0);
         if (n % 4 != 0)
            chk(mem[(bufa + n) / 4][8 * (n % 4) +: 8] == 8'hAA, "R4 tail lanes untouched",
                mem[(bufa + n) / 4], 32'hAAAA_AAAA);
         exp_ptr = (slot == SLOTS - 1) ? RING : exp_ptr + 32;
         e_bytes += n + 4; e_frames++;
         if (cls == 1) e_mc++;
         if (cls == 2) e_bc++;
         chk(cur_desc == AW'(exp_ptr), "R6 pointer step/wrap", cur_desc, exp_ptr);
         chk(stat_bytes == STAT_W'(e_bytes), "R8 byte count", stat_bytes, e_bytes);
         chk(stat_frames == STAT_W'(e_frames), "R8 frame count", stat_frames, e_frames);
         chk(stat_mcast == STAT_W'(e_mc), "R7 multicast count", stat_mcast, e_mc);
         chk(stat_bcast == STAT_W'(e_bc), "R7 broadcast count", stat_bcast, e_bc);
         chk(n_done == d0 + 1, "R10 one done pulse", n_done, d0 + 1);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      int hi_cnt, d0;
      for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(s_ready == 1'b1 && mem_req == 1'b0, "R11 reset handshake", {s_ready, mem_req}, 2'b10);
      chk(stat_bytes == 0 && stat_frames == 0 && stat_mcast == 0 && stat_bcast == 0,
          "R11 counters zero", stat_frames, 0);
      chk(cur_desc == '0, "R11 pointer zero", cur_desc, 0);

      // R1 refusal while disabled
      rx_en = 1'b0; s_valid = 1'b1; s_data = 8'h55; hi_cnt = 0; d0 = n_done;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (s_ready) hi_cnt++;
      end
      s_valid = 1'b0; rx_en = 1'b1;
      chk(hi_cnt == 0, "R1 ready low while disabled", hi_cnt, 0);
      chk(n_done == d0 && n_rd == 0, "R1 nothing started", n_done - d0, 0);

      // ring initialisation
      @(negedge clk); ring_load = 1'b1;
      @(negedge clk); ring_load = 1'b0;
      chk(cur_desc == AW'(RING), "R6 ring load", cur_desc, RING);

      for (int n = 1; n <= 20; n++) run_frame(n, n % 3, n, (n % 9) != 5);

      // reload mid-ring
      @(negedge clk); ring_load = 1'b1;
      @(negedge clk); ring_load = 1'b0;
      exp_ptr = RING;
      chk(cur_desc == AW'(RING), "R6 ring reload", cur_desc, RING);

      for (int n = 21; n <= 40; n++) run_frame(n, n % 3, n, (n % 9) != 5);
      run_frame(12, 2, 99, 1'b0);
      run_frame(12, 1, 98, 1'b1);

      chk(n_hold_bad == 0, "R9 ready during memory access", n_hold_bad, 0);
      chk(n_wide == 0, "R10 done pulse width", n_wide, 0);
      finish_run();
   end

endmodule